// File: doc/BRIEF.md
# Multicycle Byte-Datapath RISC Core

A compact processor core that runs a small subset of a 32-bit three-format RISC instruction set on an 8-bit datapath. Instructions and data share one byte-wide external memory. The memory is read combinationally: read data must be valid in the same cycle that the address and the read strobe are driven. Writes are taken at the clock edge that ends a cycle in which the write strobe is high.

Every instruction word is assembled from four byte reads, with the most significant byte first. A controller state machine then decodes the word, executes it, and performs any single-byte memory access. The core has eight 8-bit registers, an ALU, an 8-bit program counter and a control FSM. One clock is used, with an active-low asynchronous reset.

Top module: `byte_risc_core`

## Requirements
- R1: While reset is low, the core drives address 0 with the read strobe high and the write strobe low. After release it fetches from address 0.
- R2: Fetch reads addresses PC, PC+1, PC+2 and PC+3 in four consecutive cycles, with the read strobe high. The bytes fill the 32-bit instruction word from bit 31 downward. PC then advances by 4 and stays a multiple of 4 at the start of every fetch.
- R3: There are eight registers. Register 0 always reads as zero, and writes to it are discarded. Each 5-bit register field selects a register by its low 3 bits only. ra is bits 25:21, rb is bits 20:16 and rd is bits 15:11.
- R4: An instruction with opcode (bits 31:26) equal to 0 is R-type, with the function code in bits 5:0. The function codes are 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, and 0x2A set-less-than. Each writes rd = ra op rb, modulo 256. Set-less-than compares the operands as signed values and writes 1 or 0.
- R5: An R-type instruction with any other function code writes no register. Any opcode not listed in R4 and R6–R10 does nothing beyond advancing PC by 4.
- R6: Opcode 0x08 writes rb = ra + imm, where imm is the low 8 bits of the 16-bit immediate (bits 15:0).
- R7: Opcode 0x04 compares ra with rb. When they are equal, PC becomes PC+4 + (imm << 2), modulo 256. Otherwise execution continues at PC+4.
- R8: Opcode 0x02 jumps to (low 8 bits of the 26-bit destination field) << 2, modulo 256.
- R9: Opcode 0x20 reads the byte at ra + imm and writes it into rb.
- R10: Opcode 0x28 writes rb to address ra + imm. The write strobe is high for exactly one cycle, and it is never high together with the read strobe.
- R11: Every instruction takes six cycles: four fetch cycles, one decode cycle, and one cycle of execute or memory access. The second instruction's fetch therefore begins six cycles after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_addr_o | output | 8 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, combinational from the address |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |

## Verification
The embedded assertions check five properties on every cycle:
- the write strobe is a single-cycle pulse;
- the read and write strobes are never high together;
- the four fetch addresses step by one;
- PC is word-aligned whenever a fetch begins;
- a register write is visible on the following cycle.

Instruction semantics can only be shown by the bench's scenarios, which observe results through stores to memory. These cover the ALU results over a sweep of operand pairs, the discarded writes to register 0, the decoding of the low register-field bits, immediate truncation, taken, not-taken and backward branches, jumps, load-to-store round trips, and the no-op cases.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [2:0] {
    ST_F0, ST_F1, ST_F2, ST_F3, ST_DEC, ST_EXE, ST_LD, ST_ST
  } state_e;

  typedef enum logic [2:0] {
    K_NOP, K_ALU, K_ADDI, K_BEQ, K_J, K_LB, K_SB
  } kind_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_LB    = 6'h20;
  localparam logic [5:0] OP_SB    = 6'h28;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;
endpackage

// File: rtl/brc_regfile.sv
module brc_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_idx_i,
  input  logic [AW-1:0] rb_idx_i,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  output logic [DW-1:0] ra_o,
  output logic [DW-1:0] rb_o
);
  // index 0 has no storage
  logic [DW-1:0] regs [1:NREG-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 1; i < NREG; i++) regs[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      regs[wa_i] <= wd_i;
    end
  end

  assign ra_o = (ra_idx_i == '0) ? '0 : regs[ra_idx_i];
  assign rb_o = (rb_idx_i == '0) ? '0 : regs[rb_idx_i];

  // R3
  wr_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_i != '0) |=> regs[$past(wa_i)] == $past(wd_i));
endmodule

// File: rtl/brc_alu.sv
module brc_alu
  import brc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  alu_op_e       op_i,
  output logic [DW-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(DW-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: y_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/brc_decode.sv
module brc_decode
  import brc_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] funct_i,
  output kind_e      kind_o,
  output alu_op_e    alu_op_o
);
  always_comb begin
    alu_op_o = ALU_ADD;
    kind_o   = K_NOP;
    unique case (op_i)
      OP_RTYPE: begin
        kind_o = K_ALU;
        unique case (funct_i)
          FN_ADD:  alu_op_o = ALU_ADD;
          FN_SUB:  alu_op_o = ALU_SUB;
          FN_AND:  alu_op_o = ALU_AND;
          FN_OR:   alu_op_o = ALU_OR;
          FN_SLT:  alu_op_o = ALU_SLT;
          default: kind_o   = K_NOP;
        endcase
      end
      OP_ADDI: kind_o = K_ADDI;
      OP_BEQ:  kind_o = K_BEQ;
      OP_J:    kind_o = K_J;
      OP_LB:   kind_o = K_LB;
      OP_SB:   kind_o = K_SB;
      default: kind_o = K_NOP;
    endcase
  end
endmodule

// File: rtl/brc_ctrl.sv
module brc_ctrl
  import brc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  kind_e  kind_i,
  output state_e state_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_F0:  state_d = ST_F1;
      ST_F1:  state_d = ST_F2;
      ST_F2:  state_d = ST_F3;
      ST_F3:  state_d = ST_DEC;
      ST_DEC: begin
        if (kind_i == K_LB)      state_d = ST_LD;
        else if (kind_i == K_SB) state_d = ST_ST;
        else                     state_d = ST_EXE;
      end
      default: state_d = ST_F0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_F0;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/byte_risc_core.sv
module byte_risc_core
  import brc_pkg::*;
#(
  parameter int NREG = 8,
  localparam int DW  = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_rd_o,
  output logic          mem_wr_o
);
  state_e        state;
  kind_e         kind;
  alu_op_e       dec_alu_op, alu_op;
  logic [5:0]    op_q;
  logic [AW-1:0] ra_q, rb_q, rd_q;
  logic [DW-1:0] lo_q;          // last instruction byte: imm / funct / dest
  logic [DW-1:0] pc_q, a_q, b_q;
  logic [DW-1:0] ra_val, rb_val, alu_b, alu_y, tgt_sh;
  logic          rf_we;
  logic [AW-1:0] rf_wa;
  logic [DW-1:0] rf_wd;

  brc_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .kind_i  (kind),
    .state_o (state)
  );

  brc_decode u_dec (
    .op_i     (op_q),
    .funct_i  (lo_q[5:0]),
    .kind_o   (kind),
    .alu_op_o (dec_alu_op)
  );

  brc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ra_idx_i (ra_q),
    .rb_idx_i (rb_q),
    .we_i     (rf_we),
    .wa_i     (rf_wa),
    .wd_i     (rf_wd),
    .ra_o     (ra_val),
    .rb_o     (rb_val)
  );

  assign alu_b  = (kind == K_ALU) ? b_q : lo_q;
  assign alu_op = (kind == K_ALU) ? dec_alu_op : ALU_ADD;

  brc_alu #(.DW(DW)) u_alu (
    .a_i  (a_q),
    .b_i  (alu_b),
    .op_i (alu_op),
    .y_o  (alu_y)
  );

  assign tgt_sh = {lo_q[DW-3:0], 2'b00};

  // instruction capture, field-wise; register fields keep low AW bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= '0;
      ra_q <= '0;
      rb_q <= '0;
      rd_q <= '0;
      lo_q <= '0;
    end else begin
      unique case (state)
        ST_F0: op_q <= mem_rdata_i[7:2];
        ST_F1: begin
          ra_q <= mem_rdata_i[5 +: AW];
          rb_q <= mem_rdata_i[0 +: AW];
        end
        ST_F2: rd_q <= mem_rdata_i[3 +: AW];
        ST_F3: lo_q <= mem_rdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (state == ST_DEC) begin
      a_q <= ra_val;
      b_q <= rb_val;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else if (state == ST_F3) begin
      pc_q <= pc_q + DW'(4);
    end else if (state == ST_EXE) begin
      if (kind == K_J)                       pc_q <= tgt_sh;
      else if (kind == K_BEQ && a_q == b_q)  pc_q <= pc_q + tgt_sh;
    end
  end

  always_comb begin
    rf_we = 1'b0;
    rf_wa = rb_q;
    rf_wd = alu_y;
    if (state == ST_EXE && kind == K_ALU) begin
      rf_we = 1'b1;
      rf_wa = rd_q;
    end else if (state == ST_EXE && kind == K_ADDI) begin
      rf_we = 1'b1;
    end else if (state == ST_LD) begin
      rf_we = 1'b1;
      rf_wd = mem_rdata_i;
    end
  end

  always_comb begin
    unique case (state)
      ST_F1:        mem_addr_o = pc_q + DW'(1);
      ST_F2:        mem_addr_o = pc_q + DW'(2);
      ST_F3:        mem_addr_o = pc_q + DW'(3);
      ST_LD, ST_ST: mem_addr_o = alu_y;
      default:      mem_addr_o = pc_q;
    endcase
  end

  assign mem_rd_o    = (state == ST_F0) || (state == ST_F1) || (state == ST_F2) ||
                       (state == ST_F3) || (state == ST_LD);
  assign mem_wr_o    = (state == ST_ST);
  assign mem_wdata_o = b_q;

  // R10
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> !mem_wr_o);

  // R10
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  // R2
  fetch_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_F1 || state == ST_F2 || state == ST_F3) |->
      mem_addr_o == $past(mem_addr_o) + DW'(1));

  // R2
  pc_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_F0) |-> pc_q[1:0] == 2'b00);
endmodule

// File: tb/byte_risc_core_bench.sv
module byte_risc_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_rd, mem_wr;
  logic [7:0] mem [256];
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  byte_risc_core u_byte_risc_core (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .mem_rd_o    (mem_rd),
    .mem_wr_o    (mem_wr)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

  function automatic logic [31:0] enc_r(int ra, int rb, int rd, int fn);
    return {6'h00, 5'(ra), 5'(rb), 5'(rd), 5'h00, 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(int op, int ra, int rb, int imm);
    return {6'(op), 5'(ra), 5'(rb), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int dest);
    return {6'h02, 26'(dest)};
  endfunction

  task automatic put(int a, logic [31:0] w);
    mem[a] = w[31:24]; mem[a+1] = w[23:16]; mem[a+2] = w[15:8]; mem[a+3] = w[7:0];
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic release_run(int n);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R11 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] vals [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h5A};
    bit first = 1'b1;

    // arithmetic sweep
    foreach (vals[xi]) begin
      foreach (vals[yi]) begin
        logic [7:0] x, y;
        x = vals[xi];
        y = vals[yi];
        hold_reset();
        put(0,  enc_i(8'h08, 0, 1, {8'hA5, x}));   // upper imm bits dropped (R6)
        put(4,  enc_i(8'h08, 0, 2, y));
        put(8,  enc_r(9, 10, 11, 8'h20));          // fields 9/10/11 -> r1/r2/r3 (R3)
        put(12, enc_r(1, 2, 4, 8'h22));
        put(16, enc_r(1, 2, 5, 8'h24));
        put(20, enc_r(1, 2, 6, 8'h25));
        put(24, enc_r(1, 2, 7, 8'h2A));
        put(28, enc_i(8'h28, 0, 27, 8'hC0));       // field 27 -> r3
        put(32, enc_i(8'h28, 0, 4, 8'hC1));
        put(36, enc_i(8'h28, 0, 5, 8'hC2));
        put(40, enc_i(8'h28, 0, 6, 8'hC3));
        put(44, enc_i(8'h28, 0, 7, 8'hC4));
        put(48, enc_j(12));
        if (first) begin
          #1;
          // R1 reset state
          chk("R1 addr in reset", mem_addr, 8'h00);
          chk("R1 rd strobe in reset", {7'd0, mem_rd}, 8'h01);
          chk("R1 wr strobe in reset", {7'd0, mem_wr}, 8'h00);
          release_run(1);
          chk("R2 second fetch byte addr", mem_addr, 8'h01);
          repeat (5) @(negedge clk);
          chk("R11 next instr fetch addr", mem_addr, 8'h04);
          chk("R11 next instr rd strobe", {7'd0, mem_rd}, 8'h01);
          repeat (94) @(negedge clk);
          first = 1'b0;
        end else begin
          release_run(100);
        end
        chk("R4 add/R6 addi", mem[8'hC0], 8'(x + y));
        chk("R4 sub", mem[8'hC1], 8'(x - y));
        chk("R4 and", mem[8'hC2], x & y);
        chk("R4 or", mem[8'hC3], x | y);
        chk("R4 slt signed", mem[8'hC4], ($signed(x) < $signed(y)) ? 8'h01 : 8'h00);
      end
    end

    // control flow, memory, r0 and no-op program
    hold_reset();
    mem[8'hD0] = 8'hEE;
    mem[8'hE0] = 8'h3C;
    mem[8'hE8] = 8'h96;
    put(0,  enc_i(8'h08, 0, 0, 8'h5A));           // write to r0 discarded
    put(4,  enc_i(8'h28, 0, 0, 8'hD0));
    put(8,  enc_i(8'h20, 0, 1, 8'hE0));           // r1 = 3C
    put(12, enc_i(8'h08, 0, 2, 16'hAB10));        // r2 = 10
    put(16, enc_i(8'h20, 2, 3, 8'hD8));           // r3 = mem[E8] = 96
    put(20, enc_i(8'h28, 0, 1, 8'hD1));
    put(24, enc_i(8'h28, 0, 3, 8'hD2));
    put(28, enc_i(8'h04, 1, 1, 1));               // taken -> 36
    put(32, enc_i(8'h28, 0, 1, 8'hD3));           // skipped
    put(36, enc_i(8'h04, 1, 2, 1));               // not taken
    put(40, enc_i(8'h28, 0, 3, 8'hD4));
    put(44, 32'hFC00_0000);                       // unknown opcode
    put(48, enc_i(8'h28, 0, 2, 8'hD5));
    put(52, enc_r(1, 1, 2, 8'h3F));               // unknown funct
    put(56, enc_i(8'h28, 0, 2, 8'hD6));
    put(60, enc_j(17));                           // -> 68
    put(64, enc_i(8'h28, 0, 1, 8'hD7));           // skipped
    put(68, enc_i(8'h04, 0, 0, 16'hFFFF));        // backward branch to self
    release_run(150);
    chk("R3 r0 reads zero after write", mem[8'hD0], 8'h00);
    chk("R9 lb ra=r0", mem[8'hD1], 8'h3C);
    chk("R9 lb ra+imm", mem[8'hD2], 8'h96);
    chk("R7 beq taken skips", mem[8'hD3], 8'h00);
    chk("R7 beq not taken falls through", mem[8'hD4], 8'h96);
    chk("R5 unknown opcode no-op", mem[8'hD5], 8'h10);
    chk("R5 unknown funct no write", mem[8'hD6], 8'h10);
    chk("R8 j skips", mem[8'hD7], 8'h00);
    chk("R10 sb leaves neighbour", mem[8'hD8], 8'h00);
    chk("R7 backward loop addr", (mem_addr & 8'hFC), 8'h44);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule